// File: doc/BRIEF.md
# Per-Pixel Timestamped Hit Readout

This block is the periphery hit store of a pixel matrix in which each pixel has a readout cell of its own. When a pixel's discriminated hit pulse arrives, its cell records the value of the shared timestamp bus in that cycle and raises an occupancy flag. The hit then waits in the cell. No external trigger is needed.

A fixed-priority scan looks at all occupied cells and presents one of them on a shared output bus. The bus carries a valid bit, the cell's row and column, and the timestamp held in the cell. While the consumer holds the read request high, one stored hit leaves per cycle. Each presented cell is cleared at the clock edge that accepts it. A pixel that fires while its cell is still occupied loses that hit. A saturating counter records such losses.

Top module: `pixel_hit_readout`

## Requirements
- R1: While reset is high, and after it is released, all cells are empty: `out_valid` is 0 and `lost_count` is 0.
- R2: A hit on an empty cell, sampled at a rising edge, stores the value of `ts_in` at that edge. From the next cycle the cell is occupied.
- R3: While `read_req` is low, an occupied cell keeps its hit and its timestamp, so the presented word does not change.
- R4: When several cells are occupied, the one with the lowest index is presented.
- R5: Cell index is `row*COLS + col`. The word gives `out_row` = index / COLS, `out_col` = index mod COLS and `out_ts` = the stored timestamp.
- R6: If `read_req` is high while `out_valid` is high, the presented cell is cleared at that edge. In the next cycle the next occupied cell is presented, so one word leaves per cycle while `read_req` stays high.
- R7: A hit on an occupied cell is ignored and leaves the stored timestamp unchanged. This also holds in the cycle in which that cell is being read, so the cell is empty afterwards.
- R8: `lost_count` rises by the number of hits ignored under R7 in each cycle, and saturates at its maximum value (255 by default).
- R9: `read_req` while `out_valid` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | ROWS*COLS | Discriminated hit pulse, one bit per pixel |
| ts_in | input | TS_W | Current value of the wrapping timestamp counter |
| read_req | input | 1 | Consumer takes the presented word at this edge |
| out_valid | output | 1 | A stored hit is being presented |
| out_row | output | max(1,clog2(ROWS)) | Row of the presented cell |
| out_col | output | max(1,clog2(COLS)) | Column of the presented cell |
| out_ts | output | TS_W | Timestamp stored in the presented cell |
| lost_count | output | LOST_W | Saturating count of hits lost to occupied cells |

## Verification
The assertions check the following on every cycle:
- a free cell latches the timestamp of its hit cycle;
- an occupied cell holds its timestamp and ignores further hits;
- at most one cell is granted, and it is the lowest occupied index;
- a read empties the granted cell;
- the loss counter never falls, and stays put when nothing is lost.

Some behaviours show only in the bench scenarios:
- the order in which a crowded array drains, and the row and column decode of every index;
- a timestamp captured at the wrap value;
- a hit colliding with the read of its own cell;
- saturation of the loss count.

// File: rtl/pixro_pkg.sv
package pixro_pkg;

    // width of an index field able to hold 0 .. n-1, never below one bit
    function automatic int field_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width needed to hold a count from 0 up to n
    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pixro_cell.sv
module pixro_cell #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_in,
    input  logic            clr,
    output logic            full,
    output logic [TS_W-1:0] ts_q,
    output logic            lost
);
    // a hit into an occupied cell is dropped, even in the cycle it is read
    assign lost = hit && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            ts_q <= '0;
        end else if (clr) begin
            full <= 1'b0;
        end else if (hit && !full) begin
            full <= 1'b1;
            ts_q <= ts_in;
        end
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (hit && !full) |=> (full && ts_q == $past(ts_in)));

    a_r7_ignore: assert property (@(posedge clk) disable iff (rst)
        (hit && full) |=> (ts_q == $past(ts_q)));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);

endmodule

// File: rtl/pixro_pick.sv
module pixro_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        idx = '0;
        // walk downwards so the lowest set index is the last one written
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any   = |req;
        grant = '0;
        if (any) grant[idx] = 1'b1;
    end

    always_comb begin
        a_r4_onehot: assert ($onehot0(grant));
        if (any) begin
            a_r4_lowest: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/pixro_loss.sv
module pixro_loss #(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lost_vec,
    output logic [W-1:0] count
);
    localparam int SW = pixro_pkg::count_bits(N);
    localparam int TW = W + SW;
    localparam logic [TW-1:0] TOP = TW'({W{1'b1}});

    logic [SW-1:0] step;
    logic [TW-1:0] total;

    always_comb begin
        step  = SW'($countones(lost_vec));
        total = TW'(count) + TW'(step);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= (total > TOP) ? {W{1'b1}} : total[W-1:0];
    end

    a_r8_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count >= $past(count)));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        (lost_vec == '0) |=> $stable(count));

endmodule

// File: rtl/pixel_hit_readout.sv
module pixel_hit_readout #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int TS_W   = 8,
    parameter int LOST_W = 8,
    localparam int N     = ROWS * COLS,
    localparam int RW    = pixro_pkg::field_bits(ROWS),
    localparam int CW    = pixro_pkg::field_bits(COLS),
    localparam int IW    = pixro_pkg::field_bits(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      hit_in,
    input  logic [TS_W-1:0]   ts_in,
    input  logic              read_req,
    output logic              out_valid,
    output logic [RW-1:0]     out_row,
    output logic [CW-1:0]     out_col,
    output logic [TS_W-1:0]   out_ts,
    output logic [LOST_W-1:0] lost_count
);
    typedef struct packed {
        logic            valid;
        logic [RW-1:0]   row;
        logic [CW-1:0]   col;
        logic [TS_W-1:0] ts;
    } word_t;

    logic [N-1:0]    full_vec;
    logic [N-1:0]    lost_vec;
    logic [N-1:0]    grant;
    logic [TS_W-1:0] ts_arr [N];
    logic            any;
    logic [IW-1:0]   sel;
    word_t           word;

    for (genvar g = 0; g < N; g++) begin : g_cell
        pixro_cell #(.TS_W(TS_W)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit_in[g]),
            .ts_in (ts_in),
            .clr   (grant[g] && read_req),
            .full  (full_vec[g]),
            .ts_q  (ts_arr[g]),
            .lost  (lost_vec[g])
        );
    end

    pixro_pick #(.N(N), .IW(IW)) u_pick (
        .req   (full_vec),
        .any   (any),
        .idx   (sel),
        .grant (grant)
    );

    pixro_loss #(.N(N), .W(LOST_W)) u_loss (
        .clk      (clk),
        .rst      (rst),
        .lost_vec (lost_vec),
        .count    (lost_count)
    );

    always_comb begin
        word.valid = any;
        word.row   = RW'(int'(sel) / COLS);
        word.col   = CW'(int'(sel) % COLS);
        word.ts    = ts_arr[sel];
    end

    assign out_valid = word.valid;
    assign out_row   = word.row;
    assign out_col   = word.col;
    assign out_ts    = word.ts;

    a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
        (out_valid && read_req) |=> !full_vec[$past(sel)]);

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && hit_in == '0) |=> !out_valid);

endmodule

// File: tb/test_pixel_hit_readout.sv
`timescale 1ns/1ps
module test_pixel_hit_readout;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] hit_in = '0;
    logic [7:0]  ts_in = '0;
    logic        read_req = 1'b0;
    logic        out_valid;
    logic [1:0]  out_row;
    logic [1:0]  out_col;
    logic [7:0]  out_ts;
    logic [7:0]  lost_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pixel_hit_readout #(.ROWS(4), .COLS(4), .TS_W(8), .LOST_W(8)) i_pixel_hit_readout (
        .clk        (clk),
        .rst        (rst),
        .hit_in     (hit_in),
        .ts_in      (ts_in),
        .read_req   (read_req),
        .out_valid  (out_valid),
        .out_row    (out_row),
        .out_col    (out_col),
        .out_ts     (out_ts),
        .lost_count (lost_count)
    );

    typedef struct packed {
        logic [15:0] hits;
        logic [7:0]  ts;
        logic        rd;
        logic        v;
        logic [1:0]  row;
        logic [1:0]  col;
        logic [7:0]  ets;
        logic [7:0]  lost;
    } vec_t;

    // inputs applied at one edge; expected bus and loss count right after it
    localparam vec_t TBL [13] = '{
        '{16'h0000,  8'd10, 1'b0, 1'b0, 2'd0, 2'd0,   8'd0, 8'd0}, // R1 idle
        '{16'h0020,  8'd11, 1'b0, 1'b1, 2'd1, 2'd1,  8'd11, 8'd0}, // R2 capture idx5
        '{16'h0204,  8'd12, 1'b0, 1'b1, 2'd0, 2'd2,  8'd12, 8'd0}, // R4 idx2 beats 5,9
        '{16'h0020,  8'd13, 1'b0, 1'b1, 2'd0, 2'd2,  8'd12, 8'd1}, // R7 idx5 occupied
        '{16'h0000,  8'd14, 1'b1, 1'b1, 2'd1, 2'd1,  8'd11, 8'd1}, // R6 read 2, then 5
        '{16'h0020,  8'd15, 1'b1, 1'b1, 2'd2, 2'd1,  8'd12, 8'd2}, // R7 hit during read of 5
        '{16'h8000,  8'd16, 1'b1, 1'b1, 2'd3, 2'd3,  8'd16, 8'd2}, // R6 read 9, idx15 arrives
        '{16'h0000,  8'd17, 1'b1, 1'b0, 2'd0, 2'd0,   8'd0, 8'd2}, // R6 drain last
        '{16'h0000,  8'd18, 1'b1, 1'b0, 2'd0, 2'd0,   8'd0, 8'd2}, // R9 read when empty
        '{16'h0001, 8'd255, 1'b0, 1'b1, 2'd0, 2'd0, 8'd255, 8'd2}, // R2 wrap value
        '{16'h0000,   8'd0, 1'b0, 1'b1, 2'd0, 2'd0, 8'd255, 8'd2}, // R3 hold
        '{16'h8001,   8'd1, 1'b1, 1'b1, 2'd3, 2'd3,   8'd1, 8'd3}, // R5 idx15 row3 col3
        '{16'h0000,   8'd2, 1'b1, 1'b0, 2'd0, 2'd0,   8'd0, 8'd3}  // R6 empty
    };

    task automatic apply(input logic [15:0] h, input logic [7:0] t, input logic r);
        hit_in   = h;
        ts_in    = t;
        read_req = r;
        @(negedge clk);
    endtask

    task automatic check_word(input string req, input logic v, input logic [1:0] r,
                              input logic [1:0] c, input logic [7:0] t, input logic [7:0] l);
        checks++;
        if (out_valid !== v || lost_count !== l ||
            (v && (out_row !== r || out_col !== c || out_ts !== t))) begin
            errors++;
            $display("FAIL %s: got v=%0b row=%0d col=%0d ts=%0d lost=%0d, want v=%0b row=%0d col=%0d ts=%0d lost=%0d",
                     req, out_valid, out_row, out_col, out_ts, lost_count, v, r, c, t, l);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_word("R1 in reset", 1'b0, 2'd0, 2'd0, 8'd0, 8'd0);
        rst = 1'b0;

        foreach (TBL[k]) begin
            apply(TBL[k].hits, TBL[k].ts, TBL[k].rd);
            check_word($sformatf("R2-R9 vector %0d", k), TBL[k].v, TBL[k].row,
                       TBL[k].col, TBL[k].ets, TBL[k].lost);
        end

        // fill every cell, then flood occupied cells to saturate the loss count (R8)
        apply(16'hFFFF, 8'd40, 1'b0);
        check_word("R2 fill all", 1'b1, 2'd0, 2'd0, 8'd40, 8'd3);
        for (int k = 0; k < 16; k++) apply(16'hFFFF, 8'd41, 1'b0);
        check_word("R8 saturate, R7 ts kept", 1'b1, 2'd0, 2'd0, 8'd40, 8'd255);

        // drain in index order with one word per cycle (R4, R5, R6)
        for (int k = 0; k < 16; k++) begin
            check_word($sformatf("R5 drain index %0d", k), 1'b1, 2'(k / 4), 2'(k % 4),
                       8'd40, 8'd255);
            apply(16'h0000, 8'd42, 1'b1);
        end
        check_word("R6 drained", 1'b0, 2'd0, 2'd0, 8'd0, 8'd255);

        // reset with a stored hit (R1)
        apply(16'h0010, 8'd50, 1'b0);
        check_word("R2 before reset", 1'b1, 2'd1, 2'd0, 8'd50, 8'd255);
        rst = 1'b1;
        apply(16'h0000, 8'd51, 1'b0);
        check_word("R1 reset clears", 1'b0, 2'd0, 2'd0, 8'd0, 8'd0);
        rst = 1'b0;
        apply(16'h0000, 8'd52, 1'b0);
        check_word("R1 after release", 1'b0, 2'd0, 2'd0, 8'd0, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule